// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block is the time base of a timer unit. A 16-bit up-counter advances once per count tick while the timer is switched on. The tick comes from a source multiplexer: a power-of-two divider on the bus clock, or one of three alternate tick inputs supplied from outside. When the counter rolls from its top value back to zero, an overflow flag is latched. Software clears that flag by writing a one to it. An interrupt request is driven while the flag and its enable are both set.

A neighbouring compare channel (the highest-numbered one) delivers a match pulse. When the clear-on-match mode is selected, that pulse returns the count to zero, so the counter can run with a period shorter than the full 16-bit range. The whole count is presented as one registered 16-bit word. A reader therefore always sees a value from a single clock edge, and the two bytes cannot drift apart between two accesses.

Top module: `tmr_freerun`

## Requirements
- R1: After reset, the count is 0x0000, the overflow flag is 0, the request line is 0, and the divider phase is zero.
- R2: With source code 0 and the timer enabled, prescale select k (0..7) divides the bus clock by 2^k. After N enabled clock edges counted from a zero phase, the count has advanced by floor(N / 2^k), and the first advance falls on edge number 2^k.
- R3: Each tick adds exactly one to the count, and 0xFFFF is followed by 0x0000.
- R4: While the enable is 0, the count holds its value whatever the prescale select, the source code and the alternate tick inputs do.
- R5: Dropping the enable returns the divider phase to zero, so a divide sequence that is interrupted by a disable starts afresh when the timer is enabled again.
- R6: Source code 1, 2 or 3 selects alternate tick input bit 0, 1 or 2 respectively. The count then advances once on every enabled edge at which that bit is 1, and the other bits and the divider have no effect.
- R7: With clear-on-match set, a match pulse makes the count 0x0000 at the next edge, whether or not the timer is enabled and whether or not a tick is present. With clear-on-match at 0, the match pulse is ignored.
- R8: The overflow flag is set at the edge where a tick takes the count from 0xFFFF to 0x0000. A clear caused by a match never sets it.
- R9: The request line is 1 exactly while the overflow flag and the overflow-interrupt enable are both 1.
- R10: A flag write strobe with data 1 clears the flag, and a strobe with data 0 leaves it unchanged. If a wrap happens in the same cycle as a clearing write, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_on | input | 1 | Timer enable |
| psc_sel | input | 3 | Prescale select, divide by 2^value |
| src_sel | input | 2 | Tick source: 0 divider, 1..3 alternate tick bit 0..2 |
| alt_tick | input | 3 | Alternate tick enables, one per source |
| ovf_ie | input | 1 | Overflow interrupt enable |
| clr_on_match | input | 1 | Clear-on-match mode |
| ch7_match | input | 1 | Compare match pulse from the top compare channel |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write data, 1 clears |
| count | output | 16 | Current count value |
| ovf_flag | output | 1 | Overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The divider is swept over all eight select codes, and the count is compared with floor(N / 2^k) on every edge up to three full periods. This exposes a wrong ratio, an off-by-one in the first tick and a wrong phase. An enable/disable/enable sequence, timed so that a kept phase would produce one tick, separates the phase reset from a simple freeze. The alternate sources are driven with three different bit patterns at the same time, so a wrong source mapping gives a different count. Two full 16-bit runs check the wrap against a match clear and against a clearing write that lands on the wrap edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SRC_DIV  = 2'd0,
    SRC_ALT0 = 2'd1,
    SRC_ALT1 = 2'd2,
    SRC_ALT2 = 2'd3
  } tmr_src_e;

  // Number of bus clocks per tick for a given prescale code.
  function automatic int unsigned div_ratio(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // Ticks produced after n enabled edges from zero phase.
  function automatic int unsigned ticks_after(input int unsigned n,
                                              input int unsigned code);
    return n / div_ratio(code);
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             div_tick
);
  localparam int PH_W = (1 << SEL_W) - 1;

  logic [PH_W-1:0] phase;
  logic [PH_W:0]   wide_mask;
  logic [PH_W-1:0] mask;

  assign wide_mask = ((PH_W+1)'(1) << sel) - (PH_W+1)'(1);
  assign mask      = wide_mask[PH_W-1:0];
  assign div_tick  = run && ((phase & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= '0;
    else if (run) phase <= phase + PH_W'(1);
    else          phase <= '0;
  end
endmodule

// File: rtl/tmr_tick_mux.sv
module tmr_tick_mux #(
  parameter int SRC_W = 2
) (
  input  logic                    run,
  input  logic [SRC_W-1:0]        src,
  input  logic                    div_tick,
  input  logic [(1<<SRC_W)-2:0]   alt_tick,
  output logic                    tick
);
  localparam int N_SRC = 1 << SRC_W;

  logic [N_SRC-1:0] cand;

  assign cand[0] = div_tick;
  for (genvar i = 1; i < N_SRC; i++) begin : g_alt
    assign cand[i] = alt_tick[i-1];
  end

  assign tick = run && cand[src];
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             zero_req,
  output logic [CNT_W-1:0] value,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assign wrap_evt = tick && !zero_req && (value == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value <= '0;
    else if (zero_req) value <= '0;
    else if (tick)     value <= value + CNT_W'(1);
  end
endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_evt,
  input  logic wr,
  input  logic wdata,
  input  logic ie,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flag <= 1'b0;
    else if (wrap_evt)    flag <= 1'b1;
    else if (wr && wdata) flag <= 1'b0;
  end

  assign irq = flag && ie;
endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3,
  parameter int SRC_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tmr_on,
  input  logic [SEL_W-1:0]      psc_sel,
  input  logic [SRC_W-1:0]      src_sel,
  input  logic [(1<<SRC_W)-2:0] alt_tick,
  input  logic                  ovf_ie,
  input  logic                  clr_on_match,
  input  logic                  ch7_match,
  input  logic                  flag_wr,
  input  logic                  flag_wdata,
  output logic [CNT_W-1:0]      count,
  output logic                  ovf_flag,
  output logic                  ovf_irq
);
  // Named internal events, visible to the bound checker.
  logic div_tick;
  logic tick;
  logic zero_req;
  logic wrap_evt;

  assign zero_req = clr_on_match && ch7_match;

  tmr_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (tmr_on),
    .sel      (psc_sel),
    .div_tick (div_tick)
  );

  tmr_tick_mux #(.SRC_W(SRC_W)) u_mux (
    .run      (tmr_on),
    .src      (src_sel),
    .div_tick (div_tick),
    .alt_tick (alt_tick),
    .tick     (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .zero_req (zero_req),
    .value    (count),
    .wrap_evt (wrap_evt)
  );

  tmr_ovf_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap_evt (wrap_evt),
    .wr       (flag_wr),
    .wdata    (flag_wdata),
    .ie       (ovf_ie),
    .flag     (ovf_flag),
    .irq      (ovf_irq)
  );
endmodule

// File: rtl/tmr_freerun_chk.sv
module tmr_freerun_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_on,
  input logic             ovf_ie,
  input logic             flag_wr,
  input logic             flag_wdata,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             ovf_irq,
  input logic             tick,
  input logic             zero_req,
  input logic             wrap_evt
);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !zero_req) |=> (count == $past(count) + CNT_W'(1)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_on && !zero_req) |=> $stable(count));

  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !zero_req) |=> $stable(count));

  assert_match_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> (count == '0));

  assert_wrap_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag);

  assert_no_set_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_flag && !wrap_evt) |=> !ovf_flag);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (ovf_flag && ovf_ie));

  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && flag_wdata && !wrap_evt) |=> !ovf_flag);

  assert_w0_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(flag_wr && flag_wdata)) |=> ovf_flag);
endmodule

bind tmr_freerun tmr_freerun_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tmr_on     (tmr_on),
  .ovf_ie     (ovf_ie),
  .flag_wr    (flag_wr),
  .flag_wdata (flag_wdata),
  .count      (count),
  .ovf_flag   (ovf_flag),
  .ovf_irq    (ovf_irq),
  .tick       (tick),
  .zero_req   (zero_req),
  .wrap_evt   (wrap_evt)
);

// File: tb/tb_tmr_freerun.sv
module tb_tmr_freerun;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_on = 1'b0;
  logic [2:0]  psc_sel = '0;
  logic [1:0]  src_sel = '0;
  logic [2:0]  alt_tick = '0;
  logic        ovf_ie = 1'b0;
  logic        clr_on_match = 1'b0;
  logic        ch7_match = 1'b0;
  logic        flag_wr = 1'b0;
  logic        flag_wdata = 1'b0;
  logic [15:0] count;
  logic        ovf_flag;
  logic        ovf_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_freerun dut (
    .clk(clk), .rst_n(rst_n), .tmr_on(tmr_on), .psc_sel(psc_sel),
    .src_sel(src_sel), .alt_tick(alt_tick), .ovf_ie(ovf_ie),
    .clr_on_match(clr_on_match), .ch7_match(ch7_match),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .count(count), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Disable, zero the count through the match path, leave disabled.
  task automatic zero_count();
    tmr_on = 1'b0;
    clr_on_match = 1'b1;
    ch7_match = 1'b1;
    step(1);
    ch7_match = 1'b0;
    clr_on_match = 1'b0;
  endtask

  initial begin
    int pat_cnt;
    int held;
    step(2);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 flag", ovf_flag, 0);
    check("R1 irq", ovf_irq, 0);
    rst_n = 1'b1;
    step(1);

    // R2 divider sweep over every select code
    for (int k = 0; k < 8; k++) begin
      zero_count();
      check("R7 zero while off", count, 0);
      psc_sel = 3'(k);
      src_sel = 2'd0;
      tmr_on = 1'b1;
      for (int n = 1; n <= 3 * (1 << k) + 1; n++) begin
        step(1);
        check($sformatf("R2 sel=%0d n=%0d", k, n), count, n >> k);
      end
    end

    // R4 hold while disabled, with every tick source active
    tmr_on = 1'b0;
    step(1);
    held = count;
    alt_tick = 3'b111;
    for (int s = 0; s < 4; s++) begin
      src_sel = 2'(s);
      psc_sel = 3'd0;
      step(5);
      check($sformatf("R4 hold src=%0d", s), count, held);
    end
    alt_tick = '0;

    // R5 phase reset: 5 on, off, 3 on at divide-by-8 gives no tick
    zero_count();
    psc_sel = 3'd3;
    src_sel = 2'd0;
    tmr_on = 1'b1;
    step(5);
    tmr_on = 1'b0;
    step(2);
    tmr_on = 1'b1;
    step(3);
    check("R5 phase restart", count, 0);
    step(5);
    check("R5 first tick after restart", count, 1);

    // R6 alternate sources with distinct patterns on all bits
    for (int s = 1; s < 4; s++) begin
      zero_count();
      src_sel = 2'(s);
      psc_sel = 3'd0;
      tmr_on = 1'b1;
      pat_cnt = 0;
      for (int i = 0; i < 30; i++) begin
        alt_tick = {3'(i % 5 == 0), 3'(i % 3 == 0)} [2:0];
        alt_tick = {(i % 5 == 0), (i % 3 == 0), (i % 2 == 0)};
        if (alt_tick[s-1]) pat_cnt++;
        step(1);
      end
      alt_tick = '0;
      check($sformatf("R6 src=%0d", s), count, pat_cnt);
    end

    // R7 match ignored without clear mode, honoured with it while ticking
    src_sel = 2'd0;
    psc_sel = 3'd0;
    held = count;
    ch7_match = 1'b1;
    step(1);
    ch7_match = 1'b0;
    check("R7 match ignored", count, (held + 1) & 16'hFFFF);
    clr_on_match = 1'b1;
    ch7_match = 1'b1;
    step(1);
    ch7_match = 1'b0;
    clr_on_match = 1'b0;
    check("R7 match clears during tick", count, 0);
    check("R8 no flag on match clear", ovf_flag, 0);

    // R3 / R8 / R9 first full run from zero
    step(65535);
    check("R3 top value", count, 16'hFFFF);
    check("R8 flag before wrap", ovf_flag, 0);
    step(1);
    check("R3 wrap to zero", count, 0);
    check("R8 flag on wrap", ovf_flag, 1);
    check("R9 irq masked", ovf_irq, 0);
    ovf_ie = 1'b1;
    step(1);
    check("R9 irq enabled", ovf_irq, 1);

    // R10 write zero keeps, write one clears
    flag_wr = 1'b1; flag_wdata = 1'b0;
    step(1);
    flag_wr = 1'b0;
    check("R10 write0 keeps", ovf_flag, 1);
    flag_wr = 1'b1; flag_wdata = 1'b1;
    step(1);
    flag_wr = 1'b0; flag_wdata = 1'b0;
    check("R10 write1 clears", ovf_flag, 0);
    check("R9 irq follows flag", ovf_irq, 0);

    // R10 wrap beats a clearing write in the same cycle
    clr_on_match = 1'b1;
    ch7_match = 1'b1;
    step(1);
    ch7_match = 1'b0;
    clr_on_match = 1'b0;
    check("R7 clear before second run", count, 0);
    step(65535);
    check("R3 top value again", count, 16'hFFFF);
    flag_wr = 1'b1; flag_wdata = 1'b1;
    step(1);
    flag_wr = 1'b0; flag_wdata = 1'b0;
    check("R10 wrap wins over write", ovf_flag, 1);
    check("R3 second wrap", count, 0);
    check("R9 irq on second wrap", ovf_irq, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule